// File: doc/BRIEF.md
# DRAM Software Command Injector

This block lets a host place single DRAM commands on the command bus of a memory controller without going through the normal traffic path. A write to one control word can start a mode register set, a refresh, a single-bank precharge or a precharge of all banks, each aimed at one chip select. The injector presents the command to the controller's scheduler as a request. It holds the request, with every command field, until the scheduler grants it. In the grant cycle it clears the command bit that started it.

The same control word also lets the host force every clock-enable output low or high. When the force is released, the outputs keep the last forced level. They move again only when a self-refresh or power-down machine elsewhere in the controller sends a level-change event.

Control word layout: bit 0 mode-enable, bit 1 set-refresh, bit 2 set-precharge, bits [4:3] CKE control, bits [7:5] mode-select, bits [11:8] chip-select index, bits [15:12] reserved (read as 0), bits [31:16] mode value.

Top module: `dram_cmd_injector`

## Requirements
- R1: After a synchronous reset, `req_valid` is 0, every `cs_n` bit is 1, `ras_n`/`cas_n`/`we_n` are 1, `ba` and `addr` are 0, every `cke` bit is 0 and `rd_data` reads 0.
- R2: `rd_data` returns the stored mode value in [31:16], chip-select index in [11:8], mode-select in [7:5] and CKE control in [4:3], with 0 in [15:12]. Bits 0, 1 and 2 read 1 only while a mode register set, a refresh or a precharge (respectively) is pending.
- R3: A write with mode-enable set and both other command bits clear launches a mode register set on the cycle after the write. It shows `req_valid`=1, `ras_n`/`cas_n`/`we_n`=0/0/0, `ba` equal to mode-select, `addr` equal to the mode value, and only `cs_n[index]` low.
- R4: A write with only set-refresh set launches a refresh: pins 0/0/1, `ba`=0, `addr`=0, only the selected chip select low; mode-select and mode value are ignored.
- R5: A write with only set-precharge set and mode value bit 10 clear launches a single-bank precharge: pins 0/1/0, `ba` equal to mode-select, `addr`=0.
- R6: With only set-precharge set and mode value bit 10 set, the command is a precharge of all banks: pins 0/1/0, `addr`=16'h0400, `ba`=0, whatever mode-select holds.
- R7: A write whose three command bits are all 0, or have more than one bit set, launches nothing.
- R8: A pending request and all its command outputs stay unchanged until `req_grant` is sampled high. On the cycle after that grant `req_valid` is 0, the outputs are idle and the command bit reads back 0.
- R9: While a request is pending, a write changes only the CKE control field. Command bits, mode-select, chip-select index and mode value keep their values, and so do the command outputs.
- R10: CKE control 01 drives all `cke` bits low, and 10 drives them high, on the second clock edge after the write.
- R11: CKE control 00 or the reserved 11 leaves `cke` at its current level; after a force is released the forced level remains.
- R12: A `cke_evt_valid` pulse sets `cke` to `cke_evt_level` on the next edge when CKE control is 00 or 11, and has no effect while a force (01 or 10) is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word readback |
| req_valid | output | 1 | Command request to the scheduler |
| req_grant | input | 1 | Scheduler accepts the pending command |
| ras_n | output | 1 | Row strobe of the command |
| cas_n | output | 1 | Column strobe of the command |
| we_n | output | 1 | Write enable of the command |
| ba | output | 3 | Bank address of the command |
| addr | output | 16 | Address bus of the command |
| cs_n | output | NUM_CS | Active-low chip selects |
| cke_evt_valid | input | 1 | Level-change event from power machines |
| cke_evt_level | input | 1 | Level carried by the event |
| cke | output | NUM_CS | Clock-enable outputs |

## Verification
The mode register set is swept over every chip select and every mode-select value, with a mode value computed from both. A wrong bank or address routing, or a wrong chip-select decode, therefore shows up as a mismatch. Refresh and both precharge forms are swept over the same chip selects with non-zero mode-select and scrambled mode values, which shows whether fields that should be ignored leak onto `ba` or `addr`. All eight command-bit combinations are written to separate launches from rejections. Held requests, writes while a request is pending, and the CKE force, release, reserved code and event sequences separate the hold, drop and latch behaviours.

// File: rtl/dcmd_pkg.sv
package dcmd_pkg;

    localparam int WORD_W   = 32;
    localparam int BANK_W   = 3;
    localparam int VAL_W    = 16;
    localparam int CSF_W    = 4;
    localparam int BIT_MRS  = 0;
    localparam int BIT_REF  = 1;
    localparam int BIT_PRE  = 2;
    localparam int CKE_LSB  = 3;
    localparam int BANK_LSB = 5;
    localparam int CS_LSB   = 8;
    localparam int VAL_LSB  = 16;
    localparam int ALL_BIT  = 10;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_MRS  = 2'd1,
        CMD_REF  = 2'd2,
        CMD_PRE  = 2'd3
    } cmd_kind_t;

    typedef enum logic [1:0] {
        CKE_FREE = 2'b00,
        CKE_LOW  = 2'b01,
        CKE_HIGH = 2'b10,
        CKE_RSVD = 2'b11
    } cke_ctl_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    function automatic cmd_kind_t decode_kind(input logic mrs, input logic refr, input logic pre);
        case ({mrs, refr, pre})
            3'b100:  return CMD_MRS;
            3'b010:  return CMD_REF;
            3'b001:  return CMD_PRE;
            default: return CMD_NONE;
        endcase
    endfunction

    function automatic cmd_pins_t kind_pins(input cmd_kind_t k);
        case (k)
            CMD_MRS: return '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            CMD_REF: return '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_PRE: return '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            default: return '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/dcmd_regs.sv
module dcmd_regs
    import dcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pending,
    input  cmd_kind_t         pend_kind,
    output cke_ctl_t          cke_ctl,
    output logic [WORD_W-1:0] rd_data
);

    logic [VAL_W-1:0]  val_q;
    logic [CSF_W-1:0]  cs_q;
    logic [BANK_W-1:0] bank_q;
    cke_ctl_t          cke_q;
    logic              unused_rsvd;

    assign unused_rsvd = ^wr_data[VAL_LSB-1:CS_LSB+CSF_W] ^ ^wr_data[BIT_PRE:BIT_MRS];

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q  <= '0;
            cs_q   <= '0;
            bank_q <= '0;
            cke_q  <= CKE_FREE;
        end else if (wr_en) begin
            cke_q <= cke_ctl_t'(wr_data[CKE_LSB +: 2]);
            if (!pending) begin
                val_q  <= wr_data[VAL_LSB +: VAL_W];
                cs_q   <= wr_data[CS_LSB +: CSF_W];
                bank_q <= wr_data[BANK_LSB +: BANK_W];
            end
        end
    end

    assign cke_ctl = cke_q;
    assign rd_data = {val_q, 4'b0000, cs_q, bank_q, cke_q,
                      pending && (pend_kind == CMD_PRE),
                      pending && (pend_kind == CMD_REF),
                      pending && (pend_kind == CMD_MRS)};

    // R9: stored fields do not move while a request is pending
    a_r9_fields_frozen: assert property (@(posedge clk) disable iff (rst)
        pending |=> $stable(val_q) && $stable(cs_q) && $stable(bank_q));

endmodule

// File: rtl/dcmd_launch.sv
module dcmd_launch
    import dcmd_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              f_mrs,
    input  logic              f_ref,
    input  logic              f_pre,
    input  logic [BANK_W-1:0] f_bank,
    input  logic [CS_W-1:0]   f_cs,
    input  logic [VAL_W-1:0]  f_val,
    input  logic              grant,
    output logic              pending,
    output cmd_kind_t         kind,
    output cmd_pins_t         pins,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic [NUM_CS-1:0] cs_n
);

    cmd_kind_t         new_kind;
    logic              pend_q;
    cmd_kind_t         kind_q;
    logic [BANK_W-1:0] ba_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CS_W-1:0]   cs_q;
    logic              launch;

    assign new_kind = decode_kind(f_mrs, f_ref, f_pre);
    assign launch   = wr_en && !pend_q && (new_kind != CMD_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            kind_q <= CMD_NONE;
            ba_q   <= '0;
            addr_q <= '0;
            cs_q   <= '0;
        end else if (pend_q) begin
            if (grant) begin
                pend_q <= 1'b0;
                kind_q <= CMD_NONE;
            end
        end else if (launch) begin
            pend_q <= 1'b1;
            kind_q <= new_kind;
            cs_q   <= f_cs;
            case (new_kind)
                CMD_MRS: begin
                    ba_q   <= f_bank;
                    addr_q <= ADDR_W'(f_val);
                end
                CMD_PRE: begin
                    ba_q   <= f_val[ALL_BIT] ? '0 : f_bank;
                    addr_q <= ADDR_W'(f_val[ALL_BIT]) << ALL_BIT;
                end
                default: begin
                    ba_q   <= '0;
                    addr_q <= '0;
                end
            endcase
        end
    end

    assign pending = pend_q;
    assign kind    = kind_q;
    assign pins    = pend_q ? kind_pins(kind_q) : kind_pins(CMD_NONE);
    assign ba      = pend_q ? ba_q : '0;
    assign addr    = pend_q ? addr_q : '0;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(pend_q && (cs_q == CS_W'(g)));
    end

    // R8: request and its fields hold until granted
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        pend_q && !grant |=> pend_q && $stable(ba) && $stable(addr) && $stable(cs_n) && $stable(pins));

    // R8: a grant retires the request on the next cycle
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        pend_q && grant |=> !pend_q && (&cs_n));

    // R3: exactly one chip select is active during a request
    a_r3_one_cs: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> $countones(~cs_n) == 1);

    // R7: no request appears without a valid command write
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !pend_q && !(wr_en && (new_kind != CMD_NONE)) |=> !pend_q);

endmodule

// File: rtl/dcmd_cke.sv
module dcmd_cke
    import dcmd_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cke_ctl_t          ctl,
    input  logic              evt_valid,
    input  logic              evt_level,
    output logic [NUM_CS-1:0] cke
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
        end else begin
            case (ctl)
                CKE_LOW:  level_q <= 1'b0;
                CKE_HIGH: level_q <= 1'b1;
                default:  if (evt_valid) level_q <= evt_level;
            endcase
        end
    end

    assign cke = {NUM_CS{level_q}};

    // R10: forcing low wins over any event
    a_r10_force_low: assert property (@(posedge clk) disable iff (rst)
        ctl == CKE_LOW |=> cke == '0);

    // R11: no force and no event keeps the level
    a_r11_keep: assert property (@(posedge clk) disable iff (rst)
        (ctl == CKE_FREE || ctl == CKE_RSVD) && !evt_valid |=> $stable(cke));

endmodule

// File: rtl/dram_cmd_injector.sv
module dram_cmd_injector
    import dcmd_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              req_valid,
    input  logic              req_grant,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [2:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic [NUM_CS-1:0] cs_n,
    input  logic              cke_evt_valid,
    input  logic              cke_evt_level,
    output logic [NUM_CS-1:0] cke
);

    logic      pending;
    cmd_kind_t kind;
    cmd_pins_t pins;
    cke_ctl_t  cke_ctl;

    dcmd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .pending   (pending),
        .pend_kind (kind),
        .cke_ctl   (cke_ctl),
        .rd_data   (rd_data)
    );

    dcmd_launch #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_launch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .f_mrs   (wr_data[BIT_MRS]),
        .f_ref   (wr_data[BIT_REF]),
        .f_pre   (wr_data[BIT_PRE]),
        .f_bank  (wr_data[BANK_LSB +: BANK_W]),
        .f_cs    (wr_data[CS_LSB +: CS_W]),
        .f_val   (wr_data[VAL_LSB +: VAL_W]),
        .grant   (req_grant),
        .pending (pending),
        .kind    (kind),
        .pins    (pins),
        .ba      (ba),
        .addr    (addr),
        .cs_n    (cs_n)
    );

    dcmd_cke #(.NUM_CS(NUM_CS)) u_cke (
        .clk       (clk),
        .rst       (rst),
        .ctl       (cke_ctl),
        .evt_valid (cke_evt_valid),
        .evt_level (cke_evt_level),
        .cke       (cke)
    );

    assign req_valid = pending;
    assign ras_n     = pins.ras_n;
    assign cas_n     = pins.cas_n;
    assign we_n      = pins.we_n;

    // R2: readback command bit tracks the request
    a_r2_cmd_bits: assert property (@(posedge clk) disable iff (rst)
        (|rd_data[2:0]) == req_valid);

endmodule

// File: tb/dram_cmd_injector_tb_top.sv
module dram_cmd_injector_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        req_valid;
    logic        req_grant = 1'b0;
    logic        ras_n, cas_n, we_n;
    logic [2:0]  ba;
    logic [15:0] addr;
    logic [3:0]  cs_n;
    logic        cke_evt_valid = 1'b0;
    logic        cke_evt_level = 1'b0;
    logic [3:0]  cke;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cmd_injector dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .req_valid(req_valid), .req_grant(req_grant),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cs_n(cs_n),
        .cke_evt_valid(cke_evt_valid), .cke_evt_level(cke_evt_level), .cke(cke)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic m, input logic r, input logic p,
                                         input logic [1:0] k, input logic [2:0] b,
                                         input logic [3:0] c, input logic [15:0] v);
        return {v, 4'b0000, c, b, k, p, r, m};
    endfunction

    function automatic logic [31:0] bus(input logic v, input logic [2:0] pn, input logic [2:0] b,
                                        input logic [3:0] csn, input logic [15:0] a);
        return {5'b0, v, pn, b, csn, a};
    endfunction

    function automatic logic [31:0] bus_now();
        return bus(req_valid, {ras_n, cas_n, we_n}, ba, cs_n, addr);
    endfunction

    function automatic logic [3:0] sel(input int c);
        return ~(4'b0001 << c);
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic grant_it();
        @(negedge clk);
        req_grant = 1'b1;
        @(negedge clk);
        req_grant = 1'b0;
    endtask

    task automatic evt(input logic lvl);
        @(negedge clk);
        cke_evt_valid = 1'b1;
        cke_evt_level = lvl;
        @(negedge clk);
        cke_evt_valid = 1'b0;
    endtask

    localparam logic [31:0] IDLE = {5'b0, 1'b0, 3'b111, 3'b000, 4'b1111, 16'h0000};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 bus", bus_now(), IDLE);
        chk("R1 cke", {28'b0, cke}, 32'h0);
        chk("R1 rd", rd_data, 32'h0);

        // R3 mode register set sweep over chip select and mode-select
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 8; b++) begin
                logic [15:0] v;
                v = 16'(c * 4099 + b * 257 + 16'h0A5A);
                wr(word(1, 0, 0, 2'b00, 3'(b), 4'(c), v));
                chk("R3 mrs bus", bus_now(), bus(1, 3'b000, 3'(b), sel(c), v));
                chk("R2 mrs rd", rd_data, word(1, 0, 0, 2'b00, 3'(b), 4'(c), v));
                if (b == 3) begin
                    repeat (3) @(negedge clk);
                    chk("R8 held", bus_now(), bus(1, 3'b000, 3'(b), sel(c), v));
                end
                grant_it();
                chk("R8 idle", bus_now(), IDLE);
                chk("R8 rd cleared", rd_data, word(0, 0, 0, 2'b00, 3'(b), 4'(c), v));
            end
        end

        // R4 refresh ignores mode-select and mode value
        for (int c = 0; c < 4; c++) begin
            wr(word(0, 1, 0, 2'b00, 3'd5, 4'(c), 16'hFFFF));
            chk("R4 ref bus", bus_now(), bus(1, 3'b001, 3'd0, sel(c), 16'h0));
            chk("R2 ref rd", rd_data[2:0], 32'b010);
            grant_it();
            chk("R8 ref idle", bus_now(), IDLE);
        end

        // R5 single-bank and R6 all-bank precharge
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 8; b++) begin
                logic [15:0] v;
                v = 16'(c * 7919 + b * 131) & ~16'h0400;
                wr(word(0, 0, 1, 2'b00, 3'(b), 4'(c), v));
                chk("R5 pre bus", bus_now(), bus(1, 3'b010, 3'(b), sel(c), 16'h0));
                chk("R2 pre rd", rd_data[2:0], 32'b100);
                grant_it();
                wr(word(0, 0, 1, 2'b00, 3'(b), 4'(c), v | 16'h0400));
                chk("R6 pall bus", bus_now(), bus(1, 3'b010, 3'd0, sel(c), 16'h0400));
                grant_it();
            end
        end

        // R7 all command-bit combinations
        for (int k = 0; k < 8; k++) begin
            logic exp_go;
            exp_go = (k == 1) || (k == 2) || (k == 4);
            wr(word(k[0], k[1], k[2], 2'b00, 3'd2, 4'd1, 16'h0000));
            chk("R7 launch", {31'b0, req_valid}, {31'b0, exp_go});
            if (exp_go) grant_it();
        end

        // R9 writes while pending
        wr(word(1, 0, 0, 2'b00, 3'd2, 4'd1, 16'h1357));
        wr(word(0, 1, 0, 2'b10, 3'd5, 4'd3, 16'hBEEF));
        chk("R9 bus kept", bus_now(), bus(1, 3'b000, 3'd2, sel(1), 16'h1357));
        chk("R9 rd kept", rd_data, word(1, 0, 0, 2'b10, 3'd2, 4'd1, 16'h1357));
        grant_it();
        chk("R9 no second cmd", bus_now(), IDLE);

        // R10 / R11 / R12 clock-enable control
        @(negedge clk);
        chk("R10 high", {28'b0, cke}, 32'hF);
        wr(word(0, 0, 0, 2'b01, 3'd0, 4'd0, 16'h0));
        @(negedge clk);
        chk("R10 low", {28'b0, cke}, 32'h0);
        wr(word(0, 0, 0, 2'b10, 3'd0, 4'd0, 16'h0));
        @(negedge clk);
        chk("R10 high again", {28'b0, cke}, 32'hF);
        wr(word(0, 0, 0, 2'b00, 3'd0, 4'd0, 16'h0));
        repeat (4) @(negedge clk);
        chk("R11 release keeps", {28'b0, cke}, 32'hF);
        evt(1'b0);
        chk("R12 event low", {28'b0, cke}, 32'h0);
        wr(word(0, 0, 0, 2'b11, 3'd0, 4'd0, 16'h0));
        repeat (3) @(negedge clk);
        chk("R11 reserved keeps", {28'b0, cke}, 32'h0);
        evt(1'b1);
        chk("R12 event under reserved", {28'b0, cke}, 32'hF);
        wr(word(0, 0, 0, 2'b01, 3'd0, 4'd0, 16'h0));
        @(negedge clk);
        evt(1'b1);
        chk("R12 event blocked by force", {28'b0, cke}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule